// File: doc/BRIEF.md
# Event-to-Task Signal Router

This block connects pulse-type event outputs of on-chip peripherals to pulse-type task inputs of other peripherals, so that one peripheral can start another with no processor involvement. Each routing channel holds three selectors: one picks the event line it listens to, one picks the task line it drives, and an optional second one picks an extra task line that fires together with the first. An enabled channel turns a one-cycle pulse on its event line into a one-cycle pulse on its task lines, one clock later.

Software configures the block over a small word-addressed register bus with a write strobe and a combinational read path. Channel enables are never written directly. Separate set-mask and clear-mask registers change them, and a read-only register reports them. Channels can also be gathered into groups. Each group has a membership mask, plus two trigger registers that enable or disable all of its members at once. The same group triggers also appear as extra lines in the internal task vector, so an event can switch whole channel sets on or off.

Selector values address lines by index. External task lines are numbered 0 to NUM_TSK-1. The group triggers follow them, with group g's enable at NUM_TSK+2g and its disable at NUM_TSK+2g+1. Any index that has no line behind it counts as unconnected.

Top module: `evt_router`

## Requirements
- R1: After reset, the enable status reads 0, every group mask reads 0, every event, task and fork selector reads all ones (255, which is unconnected), and `task_o` is 0.
- R2: The word at address 0x00 returns the channel enables, with bit n set when channel n is enabled. A write to 0x00 does not change them.
- R3: Writing a mask to address 0x01 sets every enable bit whose mask bit is 1. All other enable bits keep their values.
- R4: Writing a mask to address 0x02 clears the enable bits whose mask bit is 1, so all ones disables every channel. When a set and a clear reach the same bit in the same cycle, the bit ends up cleared.
- R5: Address 0x10+g holds the membership mask of group g, with bit n meaning channel n is a member. It reads back what was written, and writing 0 leaves the group empty.
- R6: A write to address 0x18+2g with data bit 0 at 1 enables every member of group g. The same write to 0x19+2g disables them. If data bit 0 is 0, the write has no effect.
- R7: The selectors of channel c sit at 0x40+c (event), 0x80+c (task) and 0xC0+c (fork). An event pulse on the selected line in cycle t gives a one-cycle pulse on the selected task line in cycle t+1, but only if the channel was enabled in cycle t.
- R8: A routed event fires the fork task line as well as the primary task line, in the same cycle.
- R9: When several channels drive the same task line, the line is the OR of their pulses.
- R10: An event selector at or above NUM_EVT, or a task or fork selector that names no line, never produces a pulse and never changes any enable.
- R11: A routed pulse on task index NUM_TSK+2g enables group g's members, and one on NUM_TSK+2g+1 disables them. The enable change shows one cycle after the internal pulse, and a disable wins over an enable of the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| evt_i | input | NUM_EVT | Event pulse lines |
| task_o | output | NUM_TSK | Task pulse lines |

## Verification
Routing is driven with a single channel firing, with the same event while the channel is disabled, and with an event line the channel does not select; together these separate the effect of the enable from the effect of the selector. A channel carrying a fork, and two channels aimed at one task line (driven both together and one at a time), show that the task decode both fans out and merges. Selectors pointing past the implemented range show that unconnected indices stay silent. The group tests first use bus triggers with data bit 0 set and then cleared. They then send a single event through two channels at once, one aimed at a group enable and one at a group disable over overlapping members, which checks the extra cycle of delay and the rule that clear takes priority.

// File: rtl/evt_router_pkg.sv
package evt_router_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] ADR_STAT = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_SET  = 8'h01;
    localparam logic [ADDR_W-1:0] ADR_CLR  = 8'h02;
    localparam logic [ADDR_W-1:0] ADR_GRP  = 8'h10;
    localparam logic [ADDR_W-1:0] ADR_TRG  = 8'h18;
    localparam logic [1:0]        PG_EVS   = 2'd1;
    localparam logic [1:0]        PG_TKS   = 2'd2;
    localparam logic [1:0]        PG_FKS   = 2'd3;

endpackage

// File: rtl/evt_router_regs.sv
module evt_router_regs
    import evt_router_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int NUM_GRP = 4,
    parameter int SEL_W   = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_we,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [DATA_W-1:0]                 bus_rdata,
    input  logic [NUM_GRP-1:0]                grp_en_pulse,
    input  logic [NUM_GRP-1:0]                grp_dis_pulse,
    output logic [NUM_CH-1:0]                 en_o,
    output logic [NUM_CH-1:0][SEL_W-1:0]      evs_o,
    output logic [NUM_CH-1:0][SEL_W-1:0]      tks_o,
    output logic [NUM_CH-1:0][SEL_W-1:0]      fks_o
);

    typedef struct packed {
        logic [NUM_CH-1:0]                en;
        logic [NUM_GRP-1:0][NUM_CH-1:0]   grp;
        logic [NUM_CH-1:0][SEL_W-1:0]     evs;
        logic [NUM_CH-1:0][SEL_W-1:0]     tks;
        logic [NUM_CH-1:0][SEL_W-1:0]     fks;
    } regs_t;

    regs_t             s_d, s_q;
    logic [NUM_CH-1:0] set_m, clr_m;
    logic [NUM_CH-1:0] wmask;

    assign wmask = bus_wdata[NUM_CH-1:0];

    always_comb begin
        s_d   = s_q;
        set_m = '0;
        clr_m = '0;
        if (bus_we) begin
            if (bus_addr == ADR_SET) set_m = set_m | wmask;
            if (bus_addr == ADR_CLR) clr_m = clr_m | wmask;
            for (int g = 0; g < NUM_GRP; g++) begin
                if (bus_addr == ADR_GRP + ADDR_W'(g))
                    s_d.grp[g] = wmask;
                if (bus_wdata[0] && bus_addr == ADR_TRG + ADDR_W'(2*g))
                    set_m = set_m | s_q.grp[g];
                if (bus_wdata[0] && bus_addr == ADR_TRG + ADDR_W'(2*g+1))
                    clr_m = clr_m | s_q.grp[g];
            end
            for (int c = 0; c < NUM_CH; c++) begin
                if (bus_addr[5:0] == 6'(c)) begin
                    if (bus_addr[7:6] == PG_EVS) s_d.evs[c] = bus_wdata[SEL_W-1:0];
                    if (bus_addr[7:6] == PG_TKS) s_d.tks[c] = bus_wdata[SEL_W-1:0];
                    if (bus_addr[7:6] == PG_FKS) s_d.fks[c] = bus_wdata[SEL_W-1:0];
                end
            end
        end
        for (int g = 0; g < NUM_GRP; g++) begin
            if (grp_en_pulse[g])  set_m = set_m | s_q.grp[g];
            if (grp_dis_pulse[g]) clr_m = clr_m | s_q.grp[g];
        end
        s_d.en = (s_q.en | set_m) & ~clr_m;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.en  <= '0;
            s_q.grp <= '0;
            s_q.evs <= '1;
            s_q.tks <= '1;
            s_q.fks <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_STAT) bus_rdata[NUM_CH-1:0] = s_q.en;
        for (int g = 0; g < NUM_GRP; g++)
            if (bus_addr == ADR_GRP + ADDR_W'(g)) bus_rdata[NUM_CH-1:0] = s_q.grp[g];
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr[5:0] == 6'(c)) begin
                if (bus_addr[7:6] == PG_EVS) bus_rdata[SEL_W-1:0] = s_q.evs[c];
                if (bus_addr[7:6] == PG_TKS) bus_rdata[SEL_W-1:0] = s_q.tks[c];
                if (bus_addr[7:6] == PG_FKS) bus_rdata[SEL_W-1:0] = s_q.fks[c];
            end
        end
    end

    assign en_o  = s_q.en;
    assign evs_o = s_q.evs;
    assign tks_o = s_q.tks;
    assign fks_o = s_q.fks;

    // R4: a clear mask always leaves its bits at 0, whatever else sets them
    a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_CLR) |=> ((s_q.en & $past(wmask)) == '0));

    // R3: a set mask turns its bits on when no disable pulse competes
    a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_SET && grp_dis_pulse == '0)
        |=> ((s_q.en & $past(wmask)) == $past(wmask)));

    // R5: writing zero empties group 0
    a_r5_grp_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_GRP && wmask == '0) |=> (s_q.grp[0] == '0));

endmodule

// File: rtl/evt_router_route.sv
module evt_router_route #(
    parameter int NUM_CH   = 8,
    parameter int NUM_EVT  = 16,
    parameter int NUM_TV   = 24,
    parameter int SEL_W    = 8,
    parameter bit HAS_FORK = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_EVT-1:0]            evt_i,
    input  logic [NUM_CH-1:0]             en_i,
    input  logic [NUM_CH-1:0][SEL_W-1:0]  evs_i,
    input  logic [NUM_CH-1:0][SEL_W-1:0]  tks_i,
    input  logic [NUM_CH-1:0][SEL_W-1:0]  fks_i,
    output logic [NUM_TV-1:0]             tv_o
);

    logic [NUM_CH-1:0][SEL_W-1:0] fks_eff;
    logic [NUM_CH-1:0]            hit;
    logic [NUM_TV-1:0]            tv_d, tv_q;

    generate
        if (HAS_FORK) begin : g_fork
            assign fks_eff = fks_i;
        end else begin : g_nofork
            assign fks_eff = '1;
        end
    endgenerate

    always_comb begin
        hit = '0;
        for (int c = 0; c < NUM_CH; c++)
            for (int e = 0; e < NUM_EVT; e++)
                if (en_i[c] && evt_i[e] && evs_i[c] == SEL_W'(e)) hit[c] = 1'b1;
    end

    always_comb begin
        tv_d = '0;
        for (int c = 0; c < NUM_CH; c++)
            for (int t = 0; t < NUM_TV; t++)
                if (hit[c] && (tks_i[c] == SEL_W'(t) || fks_eff[c] == SEL_W'(t)))
                    tv_d[t] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tv_q <= '0;
        else        tv_q <= tv_d;
    end

    assign tv_o = tv_q;

    // R7: with every channel disabled, the next cycle carries no pulse
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0) |=> (tv_q == '0));

    // R7: no pulse follows a cycle without any event
    a_r7_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == '0) |=> (tv_q == '0));

endmodule

// File: rtl/evt_router.sv
module evt_router
    import evt_router_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int NUM_GRP  = 4,
    parameter int NUM_EVT  = 16,
    parameter int NUM_TSK  = 16,
    parameter int SEL_W    = 8,
    parameter bit HAS_FORK = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [7:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_EVT-1:0]   evt_i,
    output logic [NUM_TSK-1:0]   task_o
);

    localparam int NUM_TV = NUM_TSK + 2 * NUM_GRP;

    logic [NUM_CH-1:0]             en;
    logic [NUM_CH-1:0][SEL_W-1:0]  evs, tks, fks;
    logic [NUM_TV-1:0]             tv;
    logic [NUM_GRP-1:0]            grp_en_p, grp_dis_p;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp_tap
        assign grp_en_p[g]  = tv[NUM_TSK + 2*g];
        assign grp_dis_p[g] = tv[NUM_TSK + 2*g + 1];
    end

    evt_router_regs #(
        .NUM_CH (NUM_CH),
        .NUM_GRP(NUM_GRP),
        .SEL_W  (SEL_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .grp_en_pulse (grp_en_p),
        .grp_dis_pulse(grp_dis_p),
        .en_o         (en),
        .evs_o        (evs),
        .tks_o        (tks),
        .fks_o        (fks)
    );

    evt_router_route #(
        .NUM_CH  (NUM_CH),
        .NUM_EVT (NUM_EVT),
        .NUM_TV  (NUM_TV),
        .SEL_W   (SEL_W),
        .HAS_FORK(HAS_FORK)
    ) u_route (
        .clk  (clk),
        .rst_n(rst_n),
        .evt_i(evt_i),
        .en_i (en),
        .evs_i(evs),
        .tks_i(tks),
        .fks_i(fks),
        .tv_o (tv)
    );

    assign task_o = tv[NUM_TSK-1:0];

endmodule

// File: tb/evt_router_bench.sv
module evt_router_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] evt_i = '0;
    logic [15:0] task_o;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    evt_router u_evt_router (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .evt_i    (evt_i),
        .task_o   (task_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // pulse events for one cycle, return task_o in the next two cycles
    task automatic pulse(input logic [15:0] m, output logic [15:0] t1, output logic [15:0] t2);
        @(negedge clk);
        evt_i = m;
        @(negedge clk);
        t1 = task_o;
        evt_i = '0;
        @(negedge clk);
        t2 = task_o;
    endtask

    task automatic chan(input int c, input int ev, input int tk, input int fk);
        wr(8'h40 + 8'(c), 32'(ev));
        wr(8'h80 + 8'(c), 32'(tk));
        wr(8'hC0 + 8'(c), 32'(fk));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h00, d); check("R1 enables", d, 32'h0);
        rd(8'h12, d); check("R1 group", d, 32'h0);
        rd(8'h43, d); check("R1 event sel", d, 32'hFF);
        rd(8'h83, d); check("R1 task sel", d, 32'hFF);
        rd(8'hC3, d); check("R1 fork sel", d, 32'hFF);
        check("R1 task_o", 32'(task_o), 32'h0);
    endtask

    task automatic t_enables();
        logic [31:0] d;
        wr(8'h01, 32'h05); rd(8'h00, d); check("R3 set", d, 32'h05);
        wr(8'h01, 32'h30); rd(8'h00, d); check("R3 keep others", d, 32'h35);
        wr(8'h00, 32'hFF); rd(8'h00, d); check("R2 write ignored", d, 32'h35);
        wr(8'h02, 32'h01); rd(8'h00, d); check("R4 clear one", d, 32'h34);
        wr(8'h02, 32'hFFFFFFFF); rd(8'h00, d); check("R4 clear all", d, 32'h0);
    endtask

    task automatic t_groups();
        logic [31:0] d;
        wr(8'h12, 32'hA5); rd(8'h12, d); check("R5 readback", d, 32'hA5);
        wr(8'h12, 32'h0);  rd(8'h12, d); check("R5 empty", d, 32'h0);
        wr(8'h10, 32'h0F);
        wr(8'h18, 32'h1); rd(8'h00, d); check("R6 group enable", d, 32'h0F);
        wr(8'h19, 32'h0); rd(8'h00, d); check("R6 bit0 zero ignored", d, 32'h0F);
        wr(8'h19, 32'h1); rd(8'h00, d); check("R6 group disable", d, 32'h0);
    endtask

    task automatic t_route();
        logic [15:0] a, b;
        chan(0, 3, 5, 255);
        wr(8'h01, 32'h01);
        pulse(16'h0008, a, b);
        check("R7 fires next cycle", 32'(a), 32'h20);
        check("R7 one cycle only", 32'(b), 32'h0);
        pulse(16'h0010, a, b);
        check("R7 other event silent", 32'(a), 32'h0);
        wr(8'h02, 32'h01);
        pulse(16'h0008, a, b);
        check("R7 disabled silent", 32'(a | b), 32'h0);
    endtask

    task automatic t_fork();
        logic [15:0] a, b;
        logic [31:0] d;
        chan(1, 1, 2, 9);
        rd(8'hC1, d); check("R8 fork readback", d, 32'h9);
        wr(8'h02, 32'hFF); wr(8'h01, 32'h02);
        pulse(16'h0002, a, b);
        check("R8 primary and fork", 32'(a), 32'h204);
    endtask

    task automatic t_or();
        logic [15:0] a, b;
        chan(2, 7, 11, 255);
        chan(3, 8, 11, 255);
        wr(8'h02, 32'hFF); wr(8'h01, 32'h0C);
        pulse(16'h0180, a, b);
        check("R9 merged pulse", 32'(a), 32'h800);
        pulse(16'h0100, a, b);
        check("R9 single source", 32'(a), 32'h800);
    endtask

    task automatic t_unconnected();
        logic [15:0] a, b;
        logic [31:0] d;
        chan(4, 200, 0, 255);
        chan(5, 6, 250, 250);
        wr(8'h02, 32'hFF); wr(8'h01, 32'h30);
        pulse(16'hFFFF, a, b);
        check("R10 no task pulse", 32'(a | b), 32'h0);
        rd(8'h00, d); check("R10 enables untouched", d, 32'h30);
    endtask

    task automatic t_chain();
        logic [31:0] d;
        wr(8'h10, 32'h0F);
        wr(8'h11, 32'h03);
        chan(6, 2, 16, 255);
        chan(7, 2, 19, 255);
        wr(8'h02, 32'hFF); wr(8'h01, 32'hC0);
        @(negedge clk);
        evt_i = 16'h0004;
        @(negedge clk);
        evt_i = '0;
        rd(8'h00, d); check("R11 not yet applied", d, 32'hC0);
        check("R11 internal not on task_o", 32'(task_o), 32'h0);
        @(negedge clk);
        rd(8'h00, d); check("R11 disable wins", d, 32'hCC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enables();
        t_groups();
        t_route();
        t_fork();
        t_or();
        t_unconnected();
        t_chain();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule